// File: doc/BRIEF.md
# Packet coding chain encoder

This block performs the binary coding on the transmit side of a sub-GHz FSK packet radio. Frame bytes arrive on a valid/ready byte stream. Coded bits leave on a bit-serial valid/ready stream. The framing logic upstream gives a start-of-frame pulse together with an 8-bit channel identifier. The two top bits of that identifier select one of two coding modes. In the first mode the data is only whitened with a 9-bit pseudo-noise generator. In the second mode the whitened bits then pass through a rate-1/2, constraint-length-4 convolutional encoder and a 4×4 block interleaver.

In coded mode every data bit becomes two line bits, so the data rate is half the symbol rate. The encoder is flushed with zero tail bits at the end of the frame. The last interleaver block is padded with coded zeros and then drained. A frame that requests a reserved coding value raises an error flag. Its bytes are consumed and thrown away, and no output is produced for it. Backpressure on the output stalls the whole chain and no bit is lost.

Top module: `pkt_code_enc`

## Requirements
- R1: A `sof` pulse is accepted only while the block is idle. It samples `chan_id[7:6]`: value 0 selects whitening only, value 2 selects whitening followed by the convolutional code and the interleaver, and values 1 and 3 are reserved. A frame accepted with value 0 or 2 clears `enc_err`.
- R2: Whitening uses a 9-bit register s, loaded with all ones at each accepted `sof`. Each data bit, taken MSB first within its byte, is XORed with s[0]. After each data bit the register becomes {s[0]^s[5], s[8:1]}.
- R3: With a reserved value, `enc_err` is high from the cycle after `sof` until the next accepted `sof`. `in_ready` is held high and bytes are consumed up to and including the one marked `in_last`. `out_valid` stays low for the whole frame.
- R4: The convolutional encoder sees a window {b, h2, h1, h0}, where b is the current bit and h2 is the newest previous bit. Code bit A is the parity of the window AND octal 17, and code bit B is the parity of the window AND octal 13. A is sent before B. The encoder history is cleared at each accepted `sof`.
- R5: In coded mode, 3 zero bits follow the last data bit into the encoder. They are not whitened.
- R6: In coded mode, 16 consecutive 2-bit code symbols fill a 4×4 matrix row by row. Symbol k goes to row k/4, column k%4. The matrix is drained column by column, top row first, giving 32 line bits per block.
- R7: A partly filled final block is completed with the encoder outputs for zero input bits. A coded frame of N bytes therefore yields 32·ceil((8N+3)/16) line bits.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` stays unchanged. Every bit is delivered exactly once.
- R9: `out_last` is high on exactly one transferred bit per frame, the final one.
- R10: In whitening-only mode a frame of N bytes yields exactly 8N line bits.
- R11: During and right after reset, `in_ready`, `out_valid` and `enc_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_id | input | 8 | Channel identifier; bits 7:6 select the coding mode |
| sof | input | 1 | Start-of-frame pulse |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of the frame |
| out_valid | output | 1 | Line bit valid |
| out_ready | input | 1 | Downstream accepts the line bit |
| out_bit | output | 1 | Coded line bit |
| out_last | output | 1 | Marks the final line bit of the frame |
| enc_err | output | 1 | Reserved coding value requested for the current frame |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, the 9-bit generator tapped at bit 5, constraint length 4 with polynomials 17 and 13, and a 4×4 interleaver. Frame lengths run from 1 to 40 bytes. Because 8N+3 is always odd, every coded frame ends with padding. A one-byte frame pads most of its only block, while long frames cross many drain stalls in the middle of a byte. Random output backpressure and input gaps, combined with reserved frames placed between good ones, reach the hold, error-clear and last-bit corners.

// File: rtl/pce_pkg.sv
package pce_pkg;

  typedef enum logic [1:0] {
    ENC_WHITE = 2'd0,
    ENC_RSV1  = 2'd1,
    ENC_FEC   = 2'd2,
    ENC_RSV3  = 2'd3
  } enc_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SER,
    ST_TAIL,
    ST_PAD,
    ST_FIN,
    ST_DROP
  } phase_e;

endpackage

// File: rtl/pce_whitener.sv
module pce_whitener #(
  parameter int W   = 9,
  parameter int TAP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seed,
  input  logic adv,
  output logic pn_o
);

  logic [W-1:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = lfsr_q;
    if (seed) begin
      lfsr_d = '1;
    end else if (adv) begin
      lfsr_d = {lfsr_q[0] ^ lfsr_q[TAP], lfsr_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= '1;
    end else begin
      lfsr_q <= lfsr_d;
    end
  end

  assign pn_o = lfsr_q[0];

  AST_PN_LIVE: assert property (@(posedge clk) disable iff (!rst_n) lfsr_q != '0); // R2
  AST_PN_SEED: assert property (@(posedge clk) disable iff (!rst_n) seed |=> lfsr_q == '1); // R2

endmodule

// File: rtl/pce_conv.sv
module pce_conv #(
  parameter int             K  = 4,
  parameter logic [K-1:0]   GA = 4'o17,
  parameter logic [K-1:0]   GB = 4'o13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       adv,
  input  logic       bit_i,
  output logic [1:0] sym_o
);

  logic [K-2:0] hist_q, hist_d;
  logic [K-1:0] win;

  assign win   = {bit_i, hist_q};
  assign sym_o = {^(win & GA), ^(win & GB)};

  always_comb begin
    hist_d = hist_q;
    if (clr) begin
      hist_d = '0;
    end else if (adv) begin
      hist_d = win[K-1:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  AST_CONV_CLR: assert property (@(posedge clk) disable iff (!rst_n) clr |=> hist_q == '0); // R4
  AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!clr && !adv) |=> $stable(hist_q)); // R8

endmodule

// File: rtl/pce_interleave.sv
module pce_interleave #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int SYM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [SYM_W-1:0] wr_sym,
  input  logic             rd_en,
  output logic             full_o,
  output logic             busy_o,
  output logic             rd_bit_o,
  output logic             rd_last_o
);

  localparam int DEPTH = ROWS * COLS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int HW    = (SYM_W > 1) ? $clog2(SYM_W) : 1;

  logic [SYM_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_idx_q, wr_idx_d;
  logic [RW-1:0]    row_q, row_d;
  logic [CW-1:0]    col_q, col_d;
  logic [HW-1:0]    half_q, half_d;
  logic             busy_q, busy_d;
  logic [AW-1:0]    rd_addr;
  logic [SYM_W-1:0] rd_sym;
  logic             half_end, row_end, col_end;

  assign full_o    = wr_en && (wr_idx_q == AW'(DEPTH - 1));
  assign half_end  = (half_q == HW'(SYM_W - 1));
  assign row_end   = (row_q == RW'(ROWS - 1));
  assign col_end   = (col_q == CW'(COLS - 1));
  assign rd_last_o = busy_q && half_end && row_end && col_end;
  assign busy_o    = busy_q;
  assign rd_addr   = AW'(int'(row_q) * COLS + int'(col_q));
  assign rd_sym    = mem_q[rd_addr];
  assign rd_bit_o  = rd_sym[HW'(SYM_W - 1) - half_q];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_idx_q] <= wr_sym;
    end
  end

  always_comb begin
    wr_idx_d = wr_idx_q;
    busy_d   = busy_q;
    row_d    = row_q;
    col_d    = col_q;
    half_d   = half_q;
    if (clr) begin
      wr_idx_d = '0;
      busy_d   = 1'b0;
      row_d    = '0;
      col_d    = '0;
      half_d   = '0;
    end else begin
      if (wr_en) begin
        wr_idx_d = full_o ? '0 : wr_idx_q + 1'b1;
      end
      if (full_o) begin
        busy_d = 1'b1;
      end else if (rd_en && rd_last_o) begin
        busy_d = 1'b0;
      end
      if (rd_en) begin
        if (!half_end) begin
          half_d = half_q + 1'b1;
        end else begin
          half_d = '0;
          if (!row_end) begin
            row_d = row_q + 1'b1;
          end else begin
            row_d = '0;
            col_d = col_end ? '0 : col_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      busy_q   <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      half_q   <= '0;
    end else begin
      wr_idx_q <= wr_idx_d;
      busy_q   <= busy_d;
      row_q    <= row_d;
      col_q    <= col_d;
      half_q   <= half_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !busy_q); // R6
  AST_DRAIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> busy_q); // R6
  AST_BLOCK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && rd_last_o) |=> (!busy_q && wr_idx_q == '0)); // R6

endmodule

// File: rtl/pkt_code_enc.sv
module pkt_code_enc
  import pce_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                LFSR_W   = 9,
  parameter int                LFSR_TAP = 5,
  parameter int                CONV_K   = 4,
  parameter logic [CONV_K-1:0] POLY_A   = 4'o17,
  parameter logic [CONV_K-1:0] POLY_B   = 4'o13,
  parameter int                ILV_ROWS = 4,
  parameter int                ILV_COLS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        chan_id,
  input  logic              sof,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit,
  output logic              out_last,
  output logic              enc_err
);

  localparam int ENC_LSB  = 6;
  localparam int TAIL_LEN = CONV_K - 1;
  localparam int BC_W     = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int TC_W     = (TAIL_LEN > 1) ? $clog2(TAIL_LEN) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_ni = rs_q[1];

  phase_e            state_q, state_d;
  logic              fec_q, fec_d;
  logic              err_q, err_d;
  logic              last_q, last_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [BC_W-1:0]   bit_cnt_q, bit_cnt_d;
  logic [TC_W-1:0]   tail_q, tail_d;

  enc_sel_e   chan_enc;
  logic       rsv, start, fill_en, plain_en, data_step, byte_end;
  logic       pn_bit, white_bit, enc_in;
  logic [1:0] code_sym;
  logic       ilv_full, ilv_busy, ilv_bit, ilv_last, ilv_rd;

  assign chan_enc  = enc_sel_e'(chan_id[ENC_LSB+1:ENC_LSB]);
  assign rsv       = (chan_enc == ENC_RSV1) || (chan_enc == ENC_RSV3);
  assign start     = (state_q == ST_IDLE) && sof;
  assign fill_en   = fec_q && !ilv_busy &&
                     ((state_q == ST_SER) || (state_q == ST_TAIL) || (state_q == ST_PAD));
  assign plain_en  = !fec_q && (state_q == ST_SER) && out_ready;
  assign data_step = (state_q == ST_SER) && (fill_en || plain_en);
  assign byte_end  = (bit_cnt_q == BC_W'(DATA_W - 1));
  assign white_bit = sh_q[DATA_W-1] ^ pn_bit;
  assign enc_in    = (state_q == ST_SER) ? white_bit : 1'b0;
  assign ilv_rd    = ilv_busy && out_ready;

  pce_whitener #(
    .W   (LFSR_W),
    .TAP (LFSR_TAP)
  ) u_white (
    .clk   (clk),
    .rst_n (rst_ni),
    .seed  (start),
    .adv   (data_step),
    .pn_o  (pn_bit)
  );

  pce_conv #(
    .K  (CONV_K),
    .GA (POLY_A),
    .GB (POLY_B)
  ) u_conv (
    .clk   (clk),
    .rst_n (rst_ni),
    .clr   (start),
    .adv   (fill_en),
    .bit_i (enc_in),
    .sym_o (code_sym)
  );

  pce_interleave #(
    .ROWS  (ILV_ROWS),
    .COLS  (ILV_COLS),
    .SYM_W (2)
  ) u_ilv (
    .clk       (clk),
    .rst_n     (rst_ni),
    .clr       (start),
    .wr_en     (fill_en),
    .wr_sym    (code_sym),
    .rd_en     (ilv_rd),
    .full_o    (ilv_full),
    .busy_o    (ilv_busy),
    .rd_bit_o  (ilv_bit),
    .rd_last_o (ilv_last)
  );

  always_comb begin
    state_d   = state_q;
    fec_d     = fec_q;
    err_d     = err_q;
    last_d    = last_q;
    sh_d      = sh_q;
    bit_cnt_d = bit_cnt_q;
    tail_d    = tail_q;
    unique case (state_q)
      ST_IDLE: begin
        if (sof) begin
          if (rsv) begin
            state_d = ST_DROP;
            err_d   = 1'b1;
          end else begin
            state_d = ST_LOAD;
            err_d   = 1'b0;
            fec_d   = (chan_enc == ENC_FEC);
          end
        end
      end
      ST_LOAD: begin
        if (in_valid && in_ready) begin
          sh_d      = in_data;
          last_d    = in_last;
          bit_cnt_d = '0;
          state_d   = ST_SER;
        end
      end
      ST_SER: begin
        if (data_step) begin
          sh_d      = {sh_q[DATA_W-2:0], 1'b0};
          bit_cnt_d = bit_cnt_q + 1'b1;
          if (byte_end) begin
            tail_d = '0;
            if (!last_q) begin
              state_d = ST_LOAD;
            end else if (fec_q) begin
              state_d = ST_TAIL;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
      end
      ST_TAIL: begin
        if (fill_en) begin
          tail_d = tail_q + 1'b1;
          if (tail_q == TC_W'(TAIL_LEN - 1)) begin
            state_d = ilv_full ? ST_FIN : ST_PAD;
          end
        end
      end
      ST_PAD: begin
        if (fill_en && ilv_full) begin
          state_d = ST_FIN;
        end
      end
      ST_FIN: begin
        if (!ilv_busy) begin
          state_d = ST_IDLE;
        end
      end
      ST_DROP: begin
        if (in_valid && in_last) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      fec_q     <= 1'b0;
      err_q     <= 1'b0;
      last_q    <= 1'b0;
      sh_q      <= '0;
      bit_cnt_q <= '0;
      tail_q    <= '0;
    end else begin
      state_q   <= state_d;
      fec_q     <= fec_d;
      err_q     <= err_d;
      last_q    <= last_d;
      sh_q      <= sh_d;
      bit_cnt_q <= bit_cnt_d;
      tail_q    <= tail_d;
    end
  end

  assign in_ready  = ((state_q == ST_LOAD) && !ilv_busy) || (state_q == ST_DROP);
  assign out_valid = ilv_busy || (!fec_q && (state_q == ST_SER));
  assign out_bit   = ilv_busy ? ilv_bit : white_bit;
  assign out_last  = ilv_busy ? (ilv_last && (state_q == ST_FIN))
                              : ((state_q == ST_SER) && last_q && byte_end);
  assign enc_err   = err_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni) (out_valid && !out_ready) |=> (out_valid && $stable(out_bit))); // R8
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_ni) (state_q == ST_DROP) |-> !out_valid); // R3
  AST_RSV_FLAG: assert property (@(posedge clk) disable iff (!rst_ni) (start && rsv) |=> enc_err); // R3
  AST_LAST_END: assert property (@(posedge clk) disable iff (!rst_ni) (out_valid && out_ready && out_last) |=> !out_valid); // R9

endmodule

// File: tb/sim_pkt_code_enc.sv
`timescale 1ns/1ps
module sim_pkt_code_enc;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] chan_id = '0;
  logic       sof = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       out_bit;
  logic       out_last;
  logic       enc_err;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic [7:0] fb [64];
  logic       exp_bits [2048];
  int         exp_len;

  always #10 clk = ~clk;

  pkt_code_enc u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_id   (chan_id),
    .sof       (sof),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit),
    .out_last  (out_last),
    .enc_err   (enc_err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 180000) begin
      errors++;
      $display("FAIL watchdog R9: actual cycles=%0d expected below %0d", cyc, 180000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic build_expected(input int mode, input int n);
    logic [8:0] s;
    logic       wb [1024];
    int         nw;
    logic [2:0] h;
    logic [3:0] w;
    logic [1:0] sym [512];
    int         nsym;
    s  = 9'h1FF;
    nw = 0;
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        wb[nw] = fb[i][b] ^ s[0];
        nw++;
        s = {s[0] ^ s[5], s[8:1]};
      end
    end
    exp_len = 0;
    if (mode == 0) begin
      for (int i = 0; i < nw; i++) begin
        exp_bits[exp_len] = wb[i];
        exp_len++;
      end
    end else begin
      for (int t = 0; t < 3; t++) begin
        wb[nw] = 1'b0;
        nw++;
      end
      while ((nw % 16) != 0) begin
        wb[nw] = 1'b0;
        nw++;
      end
      h    = 3'b000;
      nsym = nw;
      for (int i = 0; i < nw; i++) begin
        w      = {wb[i], h};
        sym[i] = {^(w & 4'hF), ^(w & 4'hB)};
        h      = {wb[i], h[2:1]};
      end
      for (int blk = 0; blk < nsym / 16; blk++) begin
        for (int c = 0; c < 4; c++) begin
          for (int r = 0; r < 4; r++) begin
            exp_bits[exp_len]     = sym[blk * 16 + r * 4 + c][1];
            exp_bits[exp_len + 1] = sym[blk * 16 + r * 4 + c][0];
            exp_len += 2;
          end
        end
      end
    end
  endtask

  task automatic run_frame(input int mode, input int n, input int bp_pct, input int fill);
    int  bi, got, last_cnt, last_pos, bad_idx, bad_act, bad_exp, bp_bad, vcount, guard;
    bit  done, prev_stall, prev_bit, first;
    for (int i = 0; i < n; i++) begin
      if (fill == 0) fb[i] = 8'h00;
      else if (fill == 1) fb[i] = 8'hFF;
      else fb[i] = 8'($urandom);
    end
    build_expected(mode, n);
    @(negedge clk);
    chan_id = {2'(mode), 6'($urandom)};
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
    bi = 0; got = 0; last_cnt = 0; last_pos = -1; bad_idx = -1; bad_act = 0; bad_exp = 0;
    bp_bad = 0; vcount = 0; guard = 0; done = 1'b0; prev_stall = 1'b0; prev_bit = 1'b0; first = 1'b1;
    while (!done) begin
      out_ready = (($urandom % 100) >= bp_pct);
      in_valid  = (bi < n) && (($urandom % 4) != 0);
      in_data   = fb[(bi < n) ? bi : 0];
      in_last   = (bi == n - 1);
      #1;
      if (first) begin
        if (mode == 1 || mode == 3)
          chk(enc_err == 1'b1, "R3", "error flag after reserved start", int'(enc_err), 1);
        else
          chk(enc_err == 1'b0, "R1", "error flag cleared by valid start", int'(enc_err), 0);
        first = 1'b0;
      end
      if (prev_stall && !(out_valid && out_bit == prev_bit)) bp_bad++;
      if (out_valid) vcount++;
      if (in_valid && in_ready) bi++;
      if (out_valid && out_ready) begin
        if (got < 2048 && bad_idx < 0 && out_bit != exp_bits[got]) begin
          bad_idx = got; bad_act = int'(out_bit); bad_exp = int'(exp_bits[got]);
        end
        got++;
        if (out_last) begin
          last_cnt++;
          last_pos = got;
          done = 1'b1;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_bit   = out_bit;
      if ((mode == 1 || mode == 3) && bi == n) done = 1'b1;
      guard++;
      if (guard > 20000) done = 1'b1;
      if (!done) @(negedge clk);
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    if (mode == 1 || mode == 3) begin
      chk(vcount == 0, "R3", "output during reserved frame", vcount, 0);
      chk(bi == n, "R3", "bytes consumed in reserved frame", bi, n);
      chk(enc_err == 1'b1, "R3", "error flag held after reserved frame", int'(enc_err), 1);
    end else begin
      chk(bad_idx < 0, (mode == 0) ? "R2" : "R4 R5 R6", "first wrong bit value",
          bad_act, bad_exp);
      chk(got == exp_len, (mode == 0) ? "R10" : "R7", "line bit count", got, exp_len);
      chk(last_cnt == 1 && last_pos == exp_len, "R9", "last marker position", last_pos, exp_len);
      chk(bp_bad == 0, "R8", "held bits changed under stall", bp_bad, 0);
      chk(out_valid == 1'b0, "R9", "output idle after frame", int'(out_valid), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b0 && out_valid == 1'b0 && enc_err == 1'b0, "R11",
        "outputs during reset", int'({in_ready, out_valid, enc_err}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(in_ready == 1'b0 && out_valid == 1'b0 && enc_err == 1'b0, "R11",
        "outputs after reset", int'({in_ready, out_valid, enc_err}), 0);

    run_frame(0, 1, 0, 2);
    run_frame(0, 3, 30, 0);
    run_frame(2, 1, 0, 2);
    run_frame(2, 2, 50, 1);
    run_frame(1, 2, 20, 2);
    run_frame(2, 1, 20, 0);
    run_frame(3, 1, 0, 2);
    run_frame(0, 4, 0, 2);
    run_frame(2, 5, 70, 2);
    run_frame(2, 40, 30, 2);
    for (int f = 0; f < 16; f++) begin
      int m;
      int sel;
      sel = int'($urandom % 10);
      m   = (sel < 4) ? 0 : (sel < 8) ? 2 : (sel == 8) ? 1 : 3;
      run_frame(m, 1 + int'($urandom % 40), int'($urandom % 60), 2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule